// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

This block evaluates one sum-of-products function for each of its outputs. Each output owns a small private group of product terms. A shared pool of product terms can also reach any output through a fully programmable OR plane. Every AND-plane literal and every OR-plane connection comes from configuration bits. Those bits enter one at a time through a serial shift register. A load strobe then copies them into the active configuration all at once.

The product terms draw on the true and complement forms of every bit of a parameterized input bus. The outputs are purely combinational sums, meant to feed downstream storage elements.

The configuration port has no back-pressure. The block accepts one bit on every clock cycle in which the shift enable is high, so it needs no ready signal. The data path is combinational and has no handshake.

Top module: `pla_logic_block`

## Requirements
- R1: A product term is the AND of the literals it selects. For input i of the term's field, bit 2i selects the true literal and bit 2i+1 selects the complement literal. A term that selects both literals of one input is always 0.
- R2: A product term that selects no literal evaluates to 0. With an all-zero active configuration, every output is 0.
- R3: Output o is the OR of its own DED_PT dedicated terms and of every shared term s whose routing bit (o, s) is 1. A dedicated term never affects any other output.
- R4: One shared term whose routing bit is set for several outputs drives all of those outputs at the same time.
- R5: One output can combine all of its dedicated terms together with every shared term, up to DED_PT + SHR_PT terms (37 with the default values).
- R6: The configuration word has the following layout, starting from bit 0. First come the dedicated terms, with term k of output o in field index o*DED_PT+k. Next come the shared terms, with shared term s in field index OUTS*DED_PT+s. Each of these term fields is 2*INS bits wide. After all the term fields comes the routing matrix, where bit (o, s) sits at offset o*SHR_PT+s.
- R7: While cfg_en is high, each rising clock edge shifts cfg_bit into bit 0 of the shift register. The word is therefore sent most significant bit first. While cfg_en is low, the shift register holds its value.
- R8: A cfg_load pulse copies the shift register into the active configuration in a single edge. Shifting never changes the outputs before that load.
- R9: While rst_n is low, both the shift register and the active configuration are cleared, so every output is 0.
- R10: The outputs follow in_data within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Shift enable for the configuration register |
| cfg_bit | input | 1 | Serial configuration data, most significant bit first |
| cfg_load | input | 1 | Copies the shift register into the active configuration |
| in_data | input | INS | Input literals (true form; the block derives the complements) |
| sum_out | output | OUTS | Combinational sum of products, one bit per output |

## Verification
The assertions assume that cfg_en, cfg_bit and cfg_load are driven to known values from the first clock edge after reset, since the hold and copy properties compare against their earlier values. The bench drives every control input at the falling edge and starts with all of them at 0 while reset is held. The bench also never raises cfg_load while a shift is in progress, so the word that gets copied is always complete.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Width of the term fields ahead of the routing matrix.
  function automatic int unsigned pla_terms_width(int unsigned n_terms, int unsigned n_in);
    return n_terms * 2 * n_in;
  endfunction

  // Total configuration word width.
  function automatic int unsigned pla_cfg_width(int unsigned n_out, int unsigned n_ded,
                                                int unsigned n_shr, int unsigned n_in);
    return pla_terms_width(n_out * n_ded + n_shr, n_in) + n_out * n_shr;
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic         cfg_load,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q  <= '0;
      active_q <= '0;
    end else begin
      if (cfg_en)   shift_q  <= {shift_q[W-2:0], cfg_bit};
      if (cfg_load) active_q <= shift_q;
    end
  end
endmodule

// File: rtl/pla_product_term.sv
module pla_product_term #(
  parameter int unsigned INS = 4
) (
  input  logic [INS-1:0]   lit_in,
  input  logic [2*INS-1:0] sel,
  output logic             term_out
);
  logic hit;

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < INS; i++) begin
      if (sel[2*i]   && !lit_in[i]) hit = 1'b0;
      if (sel[2*i+1] &&  lit_in[i]) hit = 1'b0;
    end
    // An empty term is forced low so it never pollutes the OR.
    term_out = hit & (|sel);
  end
endmodule

// File: rtl/pla_sum_plane.sv
module pla_sum_plane #(
  parameter int unsigned OUTS   = 2,
  parameter int unsigned DED_PT = 5,
  parameter int unsigned SHR_PT = 4
) (
  input  logic [OUTS*DED_PT-1:0] ded_terms,
  input  logic [SHR_PT-1:0]      shr_terms,
  input  logic [OUTS*SHR_PT-1:0] route,
  output logic [OUTS-1:0]        sum_out
);
  for (genvar o = 0; o < OUTS; o++) begin : g_out
    assign sum_out[o] = (|ded_terms[o*DED_PT +: DED_PT])
                      | (|(shr_terms & route[o*SHR_PT +: SHR_PT]));
  end
endmodule

// File: rtl/pla_logic_block.sv
module pla_logic_block #(
  parameter int unsigned INS    = 36,
  parameter int unsigned OUTS   = 16,
  parameter int unsigned DED_PT = 5,
  parameter int unsigned SHR_PT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  input  logic            cfg_load,
  input  logic [INS-1:0]  in_data,
  output logic [OUTS-1:0] sum_out
);
  import pla_pkg::*;

  localparam int unsigned N_DED_T = OUTS * DED_PT;
  localparam int unsigned N_TERMS = N_DED_T + SHR_PT;
  localparam int unsigned FIELD_W = 2 * INS;
  localparam int unsigned TERMS_W = pla_terms_width(N_TERMS, INS);
  localparam int unsigned CFG_W   = pla_cfg_width(OUTS, DED_PT, SHR_PT, INS);

  logic [CFG_W-1:0]   cfg_shift;
  logic [CFG_W-1:0]   cfg_active;
  logic [N_TERMS-1:0] all_terms;

  pla_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_bit  (cfg_bit),
    .cfg_load (cfg_load),
    .shift_q  (cfg_shift),
    .active_q (cfg_active)
  );

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    pla_product_term #(.INS(INS)) u_pt (
      .lit_in   (in_data),
      .sel      (cfg_active[t*FIELD_W +: FIELD_W]),
      .term_out (all_terms[t])
    );
  end

  pla_sum_plane #(.OUTS(OUTS), .DED_PT(DED_PT), .SHR_PT(SHR_PT)) u_or (
    .ded_terms (all_terms[N_DED_T-1:0]),
    .shr_terms (all_terms[N_TERMS-1:N_DED_T]),
    .route     (cfg_active[CFG_W-1:TERMS_W]),
    .sum_out   (sum_out)
  );
endmodule

// File: rtl/pla_logic_block_chk.sv
module pla_logic_block_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned OUTS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic            cfg_bit,
  input logic            cfg_load,
  input logic [W-1:0]    shift_q,
  input logic [W-1:0]    active_q,
  input logic [OUTS-1:0] sum_out
);
  // R7
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> shift_q[0] == $past(cfg_bit));
  // R7
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(shift_q));
  // R8
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> active_q == $past(shift_q));
  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(active_q));
  // R2
  empty_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> (sum_out == '0));
endmodule

bind pla_logic_block pla_logic_block_chk #(.W(CFG_W), .OUTS(OUTS)) chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_bit  (cfg_bit),
  .cfg_load (cfg_load),
  .shift_q  (cfg_shift),
  .active_q (cfg_active),
  .sum_out  (sum_out)
);

// File: tb/pla_logic_block_test.sv
module pla_logic_block_test;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int ND = 5;
  localparam int NS = 4;
  localparam int NT = NO * ND + NS;
  localparam int FW = 2 * NI;
  localparam int TW = NT * FW;
  localparam int W  = TW + NO * NS;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_bit = 0, cfg_load = 0;
  logic [NI-1:0] in_data = '0;
  logic [NO-1:0] sum_out;
  int checks = 0, errors = 0;
  logic [W-1:0] cfg_a, cfg_b;

  always #2 clk = ~clk;

  pla_logic_block #(.INS(NI), .OUTS(NO), .DED_PT(ND), .SHR_PT(NS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_load(cfg_load), .in_data(in_data), .sum_out(sum_out));

  // Reference model built from the stated layout (R6).
  function automatic logic [NO-1:0] model(input logic [W-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] tv;
    logic [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      int nsel = 0;
      logic ok = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[t*FW+2*i])   begin nsel++; if (x[i] == 1'b0) ok = 1'b0; end
        if (c[t*FW+2*i+1]) begin nsel++; if (x[i] == 1'b1) ok = 1'b0; end
      end
      tv[t] = (nsel > 0) && ok;
    end
    for (int o = 0; o < NO; o++) begin
      r[o] = 1'b0;
      for (int k = 0; k < ND; k++) if (tv[o*ND+k]) r[o] = 1'b1;
      for (int s = 0; s < NS; s++) if (tv[NO*ND+s] && c[TW+o*NS+s]) r[o] = 1'b1;
    end
    return r;
  endfunction

  // Field for term t selecting the single minterm m.
  task automatic set_minterm(inout logic [W-1:0] c, input int t, input int m);
    for (int i = 0; i < NI; i++) begin
      c[t*FW+2*i]   = m[i];
      c[t*FW+2*i+1] = ~m[i];
    end
  endtask

  task automatic shift_word(input logic [W-1:0] c, input int from, input int upto);
    for (int b = from; b > upto; b--) begin
      @(negedge clk); cfg_en = 1; cfg_bit = c[b];
    end
    @(negedge clk); cfg_en = 0; cfg_bit = 0;
  endtask

  task automatic do_load();
    @(negedge clk); cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic sweep(input logic [W-1:0] c, input string tag);
    for (int v = 0; v < (1 << NI); v++) begin
      in_data = v[NI-1:0];
      #1;
      checks++;
      if (sum_out !== model(c, in_data)) begin
        errors++;
        $display("FAIL %s in=%0h actual=%b expected=%b", tag, in_data, sum_out, model(c, in_data));
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, all outputs low for every input
    sweep('0, "R9");
    rst_n = 1;
    @(negedge clk);
    sweep('0, "R2_empty");

    // R1: single term with x0 & ~x2 on output 1, plus a contradictory term on output 0
    cfg_a = '0;
    cfg_a[(1*ND)*FW + 0] = 1'b1;
    cfg_a[(1*ND)*FW + 5] = 1'b1;
    cfg_a[0] = 1'b1; cfg_a[1] = 1'b1;
    shift_word(cfg_a, W-1, -1); do_load();
    sweep(cfg_a, "R1");
    // R10 / R1: same-cycle response to a direct input
    in_data = 4'b0001; #1; checks++;
    if (sum_out !== 3'b010) begin errors++;
      $display("FAIL R10 actual=%b expected=%b", sum_out, 3'b010); end

    // R4: shared term 0 = x3, routed to every output
    cfg_a = '0;
    cfg_a[(NO*ND)*FW + 6] = 1'b1;
    for (int o = 0; o < NO; o++) cfg_a[TW + o*NS] = 1'b1;
    shift_word(cfg_a, W-1, -1); do_load();
    sweep(cfg_a, "R4");

    // R5: output 0 uses all dedicated and all shared terms, minterms 0..8
    cfg_a = '0;
    for (int t = 0; t < ND; t++) set_minterm(cfg_a, t, t);
    for (int s = 0; s < NS; s++) begin
      set_minterm(cfg_a, NO*ND + s, ND + s);
      cfg_a[TW + s] = 1'b1;
    end
    shift_word(cfg_a, W-1, -1); do_load();
    sweep(cfg_a, "R5");
    in_data = 4'd8; #1; checks++;
    if (sum_out !== 3'b001) begin errors++;
      $display("FAIL R5 actual=%b expected=%b", sum_out, 3'b001); end

    // R3: dedicated term of output 2 stays private; unrouted shared term is ignored
    cfg_a = '0;
    set_minterm(cfg_a, 2*ND + 3, 5);
    set_minterm(cfg_a, NO*ND + 2, 9);
    shift_word(cfg_a, W-1, -1); do_load();
    sweep(cfg_a, "R3");

    // R8: partial shift of a new word leaves outputs on the old word
    cfg_b = '0;
    for (int b = 0; b < W; b++) cfg_b[b] = ($urandom % 3) == 0;
    shift_word(cfg_b, W-1, W/2);
    sweep(cfg_a, "R8_partial");
    shift_word(cfg_b, W/2, -1);
    sweep(cfg_a, "R8_before_load");
    // R7: enable low with toggling data must not disturb the shift register
    for (int k = 0; k < 6; k++) begin @(negedge clk); cfg_bit = k[0]; end
    cfg_bit = 0;
    do_load();
    sweep(cfg_b, "R7_R8");

    // R3/R6: random configurations, exhaustive inputs
    for (int n = 0; n < 25; n++) begin
      cfg_a = '0;
      for (int t = 0; t < NT; t++) begin
        int ia = $urandom % NI;
        int ib = $urandom % NI;
        if (($urandom % 5) != 0) begin
          cfg_a[t*FW + 2*ia + ($urandom % 2)] = 1'b1;
          cfg_a[t*FW + 2*ib + ($urandom % 2)] = 1'b1;
        end
      end
      for (int b = TW; b < W; b++) cfg_a[b] = $urandom % 2;
      shift_word(cfg_a, W-1, -1); do_load();
      sweep(cfg_a, "R3_R6_random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule